// File: doc/BRIEF.md
# Trace Timestamp Source Selector

This block sits in front of a trace unit and decides two things each clock: which timebase value is stamped on trace, and whether trace (and context/virtual-machine identifier trace) is permitted at the current exception level. It receives a free-running 64-bit physical counter, plus a virtual offset and a physical offset. It forms one of three timebases from them: virtual, guest-physical or raw physical. The choice follows a 2-bit select field.

Every control input only has effect while the global self-hosted-trace flag is high. When the flag is low, the timestamp falls back to the raw physical counter and both permission flags are held low. All three outputs are registered, so they follow the inputs after one clock.

The selection is held as an enumerated timebase (`TB_PHYS`, `TB_VIRT`, `TB_GUEST`) chosen with a unique case in a decoder. This is a combinational source selection with no sequential states. The transitions between timebases are free: any timebase can follow any other on the next cycle, as the select field and flag dictate.

Top module: `tts_selector`

## Requirements
- R1: While `rst_n` is low, `ts_out` is 0 and `trc_allow` and `ctx_allow` are 0.
- R2: With `sh_trc_en`=1 and `ts_sel`=2'b01, `ts_out` is `phys_cnt - virt_off` modulo 2^64.
- R3: With `sh_trc_en`=1, `ts_sel`=2'b10 and `phys_off_ok`=1, `ts_out` is `phys_cnt - phys_off` modulo 2^64.
- R4: With `sh_trc_en`=1, `ts_sel`=2'b10 and `phys_off_ok`=0, the physical offset is taken as zero, so `ts_out` is `phys_cnt`.
- R5: With `sh_trc_en`=1 and `ts_sel` equal to 2'b11 or 2'b00, `ts_out` is `phys_cnt`.
- R6: With `sh_trc_en`=0, `ts_sel` and all enable bits have no effect: `ts_out` is `phys_cnt`, and `trc_allow` and `ctx_allow` are 0.
- R7: With `sh_trc_en`=1 and `cur_el`=2'd2, `trc_allow` equals `hyp_trc_en`.
- R8: With `sh_trc_en`=1, `cur_el`=2'd0 and `host_tge`=1, `trc_allow` equals `usr_trc_en`.
- R9: With `sh_trc_en`=1 at `cur_el` 2'd1 or 2'd3, or at `cur_el`=2'd0 with `host_tge`=0, `trc_allow` is 0.
- R10: With `sh_trc_en`=1, `ctx_allow` equals `ctx_trc_en`.
- R11: Each output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phys_cnt | input | 64 | Free-running physical counter |
| virt_off | input | 64 | Virtual timebase offset |
| phys_off | input | 64 | Physical timebase offset |
| phys_off_ok | input | 1 | Physical offset applies when high |
| ts_sel | input | 2 | Timebase select: 01 virtual, 10 guest-physical, 11/00 physical |
| hyp_trc_en | input | 1 | Trace enable at EL2 |
| usr_trc_en | input | 1 | Trace enable at EL0 in host mode |
| ctx_trc_en | input | 1 | Context/VMID trace enable |
| cur_el | input | 2 | Current exception level, binary 0..3 |
| host_tge | input | 1 | Host trap-general bit |
| sh_trc_en | input | 1 | Self-hosted trace enabled |
| ts_out | output | 64 | Registered timestamp |
| trc_allow | output | 1 | Trace permitted at current level |
| ctx_allow | output | 1 | Context/VMID trace permitted |

## Verification
On every cycle after reset, the bound assertions relate each output to the inputs of the previous cycle. They cover each timebase formula, the offset qualifier, the level-by-level permission and the fallback when self-hosted trace is disabled. Modulo-2^64 wraparound occurs only when an offset exceeds the counter, and the change of timebase on the edge right after reset release needs specific stimulus. Both are shown only by the bench's directed scenarios, which are backed by its per-cycle reference model over a long random run.

// File: rtl/tts_pkg.sv
package tts_pkg;

    typedef enum logic [1:0] {
        TB_PHYS  = 2'd0,
        TB_VIRT  = 2'd1,
        TB_GUEST = 2'd2
    } tbase_e;

    localparam logic [1:0] SEL_DFLT  = 2'b00;
    localparam logic [1:0] SEL_VIRT  = 2'b01;
    localparam logic [1:0] SEL_GUEST = 2'b10;
    localparam logic [1:0] SEL_PHYS  = 2'b11;

    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_KERN = 2'd1;
    localparam logic [1:0] LVL_HYP  = 2'd2;
    localparam logic [1:0] LVL_MON  = 2'd3;

endpackage

// File: rtl/tts_src_decode.sv
module tts_src_decode
    import tts_pkg::*;
(
    input  logic       sh_on,
    input  logic [1:0] sel,
    output tbase_e     tbase
);
    always_comb begin
        tbase = TB_PHYS;
        if (sh_on) begin
            unique case (sel)
                SEL_VIRT:  tbase = TB_VIRT;
                SEL_GUEST: tbase = TB_GUEST;
                SEL_PHYS:  tbase = TB_PHYS;
                default:   tbase = TB_PHYS;
            endcase
        end
    end
endmodule

// File: rtl/tts_offset_sub.sv
module tts_offset_sub
    import tts_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic [TS_W-1:0] cnt,
    input  logic [TS_W-1:0] voff,
    input  logic [TS_W-1:0] poff,
    input  logic            poff_ok,
    input  tbase_e          tbase,
    output logic [TS_W-1:0] ts
);
    logic [TS_W-1:0] eff_poff;
    logic [TS_W-1:0] sub_off;

    assign eff_poff = poff_ok ? poff : '0;

    always_comb begin
        sub_off = '0;
        unique case (tbase)
            TB_VIRT:  sub_off = voff;
            TB_GUEST: sub_off = eff_poff;
            TB_PHYS:  sub_off = '0;
            default:  sub_off = '0;
        endcase
    end

    assign ts = cnt - sub_off;
endmodule

// File: rtl/tts_permit.sv
module tts_permit
    import tts_pkg::*;
#(
    parameter int EL_W = 2
) (
    input  logic            sh_on,
    input  logic [EL_W-1:0] lvl,
    input  logic            tge,
    input  logic            hyp_en,
    input  logic            usr_en,
    input  logic            ctx_en,
    output logic            trc_ok,
    output logic            ctx_ok
);
    always_comb begin
        trc_ok = 1'b0;
        if (sh_on) begin
            unique case (lvl)
                LVL_HYP:  trc_ok = hyp_en;
                LVL_USER: trc_ok = tge & usr_en;
                LVL_KERN: trc_ok = 1'b0;
                LVL_MON:  trc_ok = 1'b0;
                default:  trc_ok = 1'b0;
            endcase
        end
    end

    assign ctx_ok = sh_on & ctx_en;
endmodule

// File: rtl/tts_selector.sv
module tts_selector
    import tts_pkg::*;
#(
    parameter int TS_W = 64,
    parameter int EL_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] phys_cnt,
    input  logic [TS_W-1:0] virt_off,
    input  logic [TS_W-1:0] phys_off,
    input  logic            phys_off_ok,
    input  logic [1:0]      ts_sel,
    input  logic            hyp_trc_en,
    input  logic            usr_trc_en,
    input  logic            ctx_trc_en,
    input  logic [EL_W-1:0] cur_el,
    input  logic            host_tge,
    input  logic            sh_trc_en,
    output logic [TS_W-1:0] ts_out,
    output logic            trc_allow,
    output logic            ctx_allow
);
    tbase_e          tbase_d;
    logic [TS_W-1:0] ts_d;
    logic            trc_d;
    logic            ctx_d;

    tts_src_decode u_dec (
        .sh_on (sh_trc_en),
        .sel   (ts_sel),
        .tbase (tbase_d)
    );

    tts_offset_sub #(.TS_W(TS_W)) u_sub (
        .cnt     (phys_cnt),
        .voff    (virt_off),
        .poff    (phys_off),
        .poff_ok (phys_off_ok),
        .tbase   (tbase_d),
        .ts      (ts_d)
    );

    tts_permit #(.EL_W(EL_W)) u_perm (
        .sh_on  (sh_trc_en),
        .lvl    (cur_el),
        .tge    (host_tge),
        .hyp_en (hyp_trc_en),
        .usr_en (usr_trc_en),
        .ctx_en (ctx_trc_en),
        .trc_ok (trc_d),
        .ctx_ok (ctx_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_out    <= '0;
            trc_allow <= 1'b0;
            ctx_allow <= 1'b0;
        end else begin
            ts_out    <= ts_d;
            trc_allow <= trc_d;
            ctx_allow <= ctx_d;
        end
    end
endmodule

// File: rtl/tts_checker.sv
module tts_checker #(
    parameter int TS_W = 64,
    parameter int EL_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TS_W-1:0] phys_cnt,
    input logic [TS_W-1:0] virt_off,
    input logic [TS_W-1:0] phys_off,
    input logic            phys_off_ok,
    input logic [1:0]      ts_sel,
    input logic            hyp_trc_en,
    input logic            usr_trc_en,
    input logic            ctx_trc_en,
    input logic [EL_W-1:0] cur_el,
    input logic            host_tge,
    input logic            sh_trc_en,
    input logic [TS_W-1:0] ts_out,
    input logic            trc_allow,
    input logic            ctx_allow
);
    logic live;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (ts_out == '0 && !trc_allow && !ctx_allow)));

    a_r2_virt_base: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && $past(ts_sel) == 2'b01)
        |-> ts_out == $past(phys_cnt) - $past(virt_off));

    a_r3_guest_base: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && $past(ts_sel) == 2'b10 && $past(phys_off_ok))
        |-> ts_out == $past(phys_cnt) - $past(phys_off));

    a_r4_guest_nooff: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && $past(ts_sel) == 2'b10 && !$past(phys_off_ok))
        |-> ts_out == $past(phys_cnt));

    a_r5_raw_base: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && ($past(ts_sel) == 2'b11 || $past(ts_sel) == 2'b00))
        |-> ts_out == $past(phys_cnt));

    a_r6_sh_off: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(sh_trc_en))
        |-> (ts_out == $past(phys_cnt) && !trc_allow && !ctx_allow));

    a_r7_hyp_level: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && $past(cur_el) == 2'd2)
        |-> trc_allow == $past(hyp_trc_en));

    a_r8_user_host: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && $past(cur_el) == 2'd0 && $past(host_tge))
        |-> trc_allow == $past(usr_trc_en));

    a_r9_uncovered: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en) && ($past(cur_el) == 2'd1 || $past(cur_el) == 2'd3
            || ($past(cur_el) == 2'd0 && !$past(host_tge))))
        |-> !trc_allow);

    a_r10_ctx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sh_trc_en)) |-> ctx_allow == $past(ctx_trc_en));
endmodule

bind tts_selector tts_checker #(.TS_W(TS_W), .EL_W(EL_W)) u_tts_chk (.*);

// File: tb/test_tts_selector.sv
module test_tts_selector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] phys_cnt = '0, virt_off = '0, phys_off = '0;
    logic        phys_off_ok = 1'b0;
    logic [1:0]  ts_sel = 2'b00;
    logic        hyp_trc_en = 1'b0, usr_trc_en = 1'b0, ctx_trc_en = 1'b0;
    logic [1:0]  cur_el = 2'd0;
    logic        host_tge = 1'b0, sh_trc_en = 1'b0;
    logic [63:0] ts_out;
    logic        trc_allow, ctx_allow;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [63:0] exp_ts;
    logic        exp_trc, exp_ctx;
    string       tag_ts, tag_trc, tag_ctx;

    always #5 clk = ~clk;

    tts_selector i_tts_selector (.*);

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // behavioural model of the requirements, evaluated on the current inputs
    task automatic model();
        if (!sh_trc_en) begin
            exp_ts = phys_cnt; exp_trc = 0; exp_ctx = 0;
            tag_ts = "R6/R11"; tag_trc = "R6"; tag_ctx = "R6";
        end else begin
            if (ts_sel == 2'b01) begin
                exp_ts = phys_cnt - virt_off; tag_ts = "R2/R11";
            end else if (ts_sel == 2'b10 && phys_off_ok) begin
                exp_ts = phys_cnt - phys_off; tag_ts = "R3/R11";
            end else if (ts_sel == 2'b10) begin
                exp_ts = phys_cnt; tag_ts = "R4/R11";
            end else begin
                exp_ts = phys_cnt; tag_ts = "R5/R11";
            end
            if (cur_el == 2'd2) begin
                exp_trc = hyp_trc_en; tag_trc = "R7";
            end else if (cur_el == 2'd0 && host_tge) begin
                exp_trc = usr_trc_en; tag_trc = "R8";
            end else begin
                exp_trc = 1'b0; tag_trc = "R9";
            end
            exp_ctx = ctx_trc_en; tag_ctx = "R10";
        end
    endtask

    // check the previous cycle's expectation, then drive and model new inputs
    task automatic step(logic sh, logic [1:0] sel, logic [63:0] c, logic [63:0] vo,
                        logic [63:0] po, logic pok, logic [1:0] el, logic tge,
                        logic e2, logic e0, logic cx);
        @(negedge clk);
        chk64(tag_ts, ts_out, exp_ts);
        chk1(tag_trc, trc_allow, exp_trc);
        chk1(tag_ctx, ctx_allow, exp_ctx);
        sh_trc_en = sh; ts_sel = sel; phys_cnt = c; virt_off = vo; phys_off = po;
        phys_off_ok = pok; cur_el = el; host_tge = tge;
        hyp_trc_en = e2; usr_trc_en = e0; ctx_trc_en = cx;
        model();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        phys_cnt = 64'h1234; ts_sel = 2'b11; sh_trc_en = 1; hyp_trc_en = 1; ctx_trc_en = 1;
        cur_el = 2'd2;
        repeat (3) @(negedge clk);
        chk64("R1", ts_out, 64'h0);
        chk1("R1", trc_allow, 1'b0);
        chk1("R1", ctx_allow, 1'b0);
        rst_n = 1'b1;
        model();
        // virtual with wraparound
        step(1, 2'b01, 64'd10, 64'd25, 64'd0, 0, 2'd2, 0, 1, 0, 1);
        step(1, 2'b01, 64'hFFFF_0000_0000_0000, 64'h1, 64'd0, 0, 2'd2, 0, 0, 0, 0);
        // guest with and without the qualifier
        step(1, 2'b10, 64'd100, 64'd7, 64'd40, 1, 2'd0, 1, 0, 1, 1);
        step(1, 2'b10, 64'd5, 64'd7, 64'd40, 1, 2'd0, 1, 0, 0, 0);
        step(1, 2'b10, 64'd100, 64'd7, 64'd40, 0, 2'd0, 0, 1, 1, 1);
        // raw codes
        step(1, 2'b11, 64'd77, 64'd7, 64'd40, 1, 2'd1, 1, 1, 1, 0);
        step(1, 2'b00, 64'd78, 64'd7, 64'd40, 1, 2'd3, 1, 1, 1, 1);
        // self-hosted disabled: everything else ignored
        step(0, 2'b01, 64'd90, 64'd7, 64'd40, 1, 2'd2, 1, 1, 1, 1);
        step(0, 2'b10, 64'd91, 64'd7, 64'd40, 1, 2'd0, 1, 1, 1, 1);
        step(1, 2'b01, 64'd92, 64'd2, 64'd40, 1, 2'd0, 1, 1, 1, 1);
        for (int i = 0; i < 2000; i++) begin
            step($urandom_range(0, 3) != 0, 2'($urandom), {$urandom, $urandom},
                 {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
                 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        step(1, 2'b11, 64'd0, 64'd0, 64'd0, 0, 2'd1, 0, 0, 0, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule